// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches a bank of general-purpose input pins, whose values have already been synchronized to the local clock. It turns their activity into one interrupt request line. Software sets up each pin on its own through a small byte-wide register bus. A pin can be level sensed or edge sensed. An edge-sensed pin can react to one edge, or to both edges. A polarity bit picks the active level or the active edge.

An edge is found by comparing each pin with its value one clock earlier. Edge events are held in a per-pin latch until software clears them with a write-one-to-clear access. A level-sensed pin skips the latch, so its status simply follows the pin. Software can read the raw status and the status after the per-pin enable mask. The interrupt output is high whenever any masked status bit is set.

Top module: `gpio_irq_top`

## Requirements
- R1: After reset, the enable, sense, polarity and both-edges registers read 0, the raw status reads 0 and `irq_out` is low.
- R2: A pin with sense=0, both=0 and polarity=1 latches an event on a 0-to-1 change. The event stays set after the pin returns low.
- R3: A pin with sense=0, both=0 and polarity=0 latches an event on a 1-to-0 change. A 0-to-1 change on that pin sets nothing.
- R4: A pin with sense=0 and both=1 latches an event on either edge, whatever its polarity bit holds.
- R5: A pin with sense=1 shows status 1 exactly while its input equals its polarity bit. This status is not latched.
- R6: Masked status equals raw status AND enable, and `irq_out` is the OR of the masked status bits.
- R7: Writing to the clear register clears the edge latch of every pin whose data bit is 1. Bits written as 0 have no effect, and level-sensed status is unaffected.
- R8: An edge that arrives in the same cycle as a clear write for that pin leaves the event set.
- R9: Register addresses are 0 enable, 1 sense, 2 polarity, 3 both-edges, 4 clear (write only, reads 0), 5 raw status, 6 masked status. Bit n of each register belongs to pin n. Written configuration reads back unchanged.
- R10: An edge latch is set only by a change from the previous cycle. A pin held steady after a cleared event does not set the latch again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NPINS | Synchronized pin inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address (read and write) |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data, combinational from bus_addr |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A new edge on a pin and a clear write that targets the same pin can happen in the same clock cycle. This is the one place where two functions compete for a single latch bit. The bench provokes it with one task that drives the rising edge and the clear strobe at the same falling clock edge. It then expects the raw status bit to still read 1. Before this, a separate step confirms that a clear write with no edge present does empty the latch, so the surviving bit cannot be a clear that failed to act.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_ENABLE = 3'd0,
        REG_SENSE  = 3'd1,
        REG_POL    = 3'd2,
        REG_BOTH   = 3'd3,
        REG_CLEAR  = 3'd4,
        REG_RAW    = 3'd5,
        REG_MASKED = 3'd6
    } reg_sel_e;

    typedef struct packed {
        logic en;
        logic sense;
        logic pol;
        logic both;
    } pin_cfg_t;

    function automatic logic edge_hit(input logic rise, input logic fall,
                                      input logic both, input logic pol);
        if (both)
            return rise | fall;
        return pol ? rise : fall;
    endfunction

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [NPINS-1:0]       wdata,
    output pin_cfg_t [NPINS-1:0]   cfg_v,
    output logic [NPINS-1:0]       clr_v
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    assign clr_v = (wr && sel == REG_CLEAR) ? wdata : '0;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_v[i] <= '0;
            end else if (wr) begin
                case (sel)
                    REG_ENABLE: cfg_v[i].en    <= wdata[i];
                    REG_SENSE:  cfg_v[i].sense <= wdata[i];
                    REG_POL:    cfg_v[i].pol   <= wdata[i];
                    REG_BOTH:   cfg_v[i].both  <= wdata[i];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NPINS-1:0]       pin_in,
    input  pin_cfg_t [NPINS-1:0]   cfg_v,
    input  logic [NPINS-1:0]       clr_v,
    output logic [NPINS-1:0]       raw_v
);
    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] latch_q;
    logic [NPINS-1:0] hit_v;
    logic [NPINS-1:0] sense_v;

    // previous value follows the pins even in reset, so no false edge at release
    always_ff @(posedge clk) prev_q <= pin_in;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic rise, fall;
        assign rise       = pin_in[i] & ~prev_q[i];
        assign fall       = ~pin_in[i] & prev_q[i];
        assign hit_v[i]   = edge_hit(rise, fall, cfg_v[i].both, cfg_v[i].pol);
        assign sense_v[i] = cfg_v[i].sense;

        always_ff @(posedge clk) begin
            if (rst || cfg_v[i].sense)
                latch_q[i] <= 1'b0;
            else
                latch_q[i] <= (latch_q[i] & ~clr_v[i]) | hit_v[i];
        end

        assign raw_v[i] = cfg_v[i].sense ? (pin_in[i] == cfg_v[i].pol) : latch_q[i];
    end

    // R2 R8: a detected edge on an edge-sensed pin is held next cycle, clear or not
    edge_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|(hit_v & ~sense_v)) |=>
        ((latch_q & $past(hit_v & ~sense_v)) == $past(hit_v & ~sense_v)));

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (|(clr_v & ~hit_v)) |=> ((latch_q & $past(clr_v & ~hit_v)) == '0));

    // R5
    level_nolatch_chk: assert property (@(posedge clk) disable iff (rst)
        (latch_q & $past(sense_v)) == '0);
endmodule

// File: rtl/gpio_irq_rdmux.sv
module gpio_irq_rdmux
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 8
) (
    input  logic [ADDR_W-1:0]      addr,
    input  pin_cfg_t [NPINS-1:0]   cfg_v,
    input  logic [NPINS-1:0]       raw_v,
    input  logic [NPINS-1:0]       masked_v,
    output logic [NPINS-1:0]       rdata
);
    logic [NPINS-1:0] en_b, sense_b, pol_b, both_b;

    for (genvar i = 0; i < NPINS; i++) begin : g_unpack
        assign en_b[i]    = cfg_v[i].en;
        assign sense_b[i] = cfg_v[i].sense;
        assign pol_b[i]   = cfg_v[i].pol;
        assign both_b[i]  = cfg_v[i].both;
    end

    always_comb begin
        case (reg_sel_e'(addr))
            REG_ENABLE: rdata = en_b;
            REG_SENSE:  rdata = sense_b;
            REG_POL:    rdata = pol_b;
            REG_BOTH:   rdata = both_b;
            REG_RAW:    rdata = raw_v;
            REG_MASKED: rdata = masked_v;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPINS-1:0]  pin_in,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    output logic              irq_out
);
    pin_cfg_t [NPINS-1:0] cfg_v;
    logic [NPINS-1:0]     clr_v, raw_v, masked_v, en_v;

    gpio_irq_cfg #(.NPINS(NPINS)) u_cfg (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .cfg_v(cfg_v), .clr_v(clr_v)
    );

    gpio_irq_detect #(.NPINS(NPINS)) u_det (
        .clk(clk), .rst(rst), .pin_in(pin_in), .cfg_v(cfg_v),
        .clr_v(clr_v), .raw_v(raw_v)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_mask
        assign en_v[i]     = cfg_v[i].en;
        assign masked_v[i] = raw_v[i] & cfg_v[i].en;
    end

    assign irq_out = |masked_v;

    gpio_irq_rdmux #(.NPINS(NPINS)) u_rd (
        .addr(bus_addr), .cfg_v(cfg_v), .raw_v(raw_v),
        .masked_v(masked_v), .rdata(bus_rdata)
    );

    // R6
    mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (en_v == '0) |-> !irq_out);

    // R6
    raw_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (raw_v == '0) |-> !irq_out);
endmodule

// File: tb/tb_gpio_irq_top.sv
module tb_gpio_irq_top;
    localparam int unsigned NP = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pin_in = '0;
    logic          bus_wr = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [NP-1:0] bus_wdata = '0;
    logic [NP-1:0] bus_rdata;
    logic          irq_out;

    always #2.5 clk = ~clk;

    gpio_irq_top #(.NPINS(NP)) dut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    typedef struct {
        logic [2:0]    a;
        logic [NP-1:0] val;
        logic          irq;
        string         req;
    } exp_t;

    exp_t q[$];
    int   pending = 0;
    int   checks = 0;
    int   failures = 0;
    bit   done = 0;

    localparam logic [2:0] A_EN = 3'd0, A_SEN = 3'd1, A_POL = 3'd2, A_BOTH = 3'd3,
                           A_CLR = 3'd4, A_RAW = 3'd5, A_MSK = 3'd6;

    task automatic wr(input logic [2:0] a, input logic [NP-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pins(input logic [NP-1:0] v);
        @(negedge clk);
        pin_in = v;
        @(negedge clk);
    endtask

    task automatic pins_and_clear(input logic [NP-1:0] v, input logic [NP-1:0] c);
        @(negedge clk);
        pin_in = v; bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = c;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic expect_rd(input logic [2:0] a, input logic [NP-1:0] v,
                             input logic irq, input string req);
        exp_t it;
        it.a = a; it.val = v; it.irq = irq; it.req = req;
        pending++;
        q.push_back(it);
        wait (pending == 0);
    endtask

    // monitor: owns the read port, compares against queued expectations
    initial begin
        forever begin
            @(negedge clk);
            #0.5;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                bus_addr = it.a;
                #0.5;
                checks++;
                if (bus_rdata !== it.val || irq_out !== it.irq) begin
                    failures++;
                    $display("FAIL %s addr=%0d rdata=%02h irq=%b expected rdata=%02h irq=%b",
                             it.req, it.a, bus_rdata, irq_out, it.val, it.irq);
                end
                pending--;
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired checks=%0d", checks);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        expect_rd(A_EN,  8'h00, 1'b0, "R1");
        expect_rd(A_SEN, 8'h00, 1'b0, "R1");
        expect_rd(A_RAW, 8'h00, 1'b0, "R1");
        // R9 config readback
        wr(A_POL, 8'h01);
        wr(A_BOTH, 8'h04);
        wr(A_EN, 8'h07);
        expect_rd(A_POL,  8'h01, 1'b0, "R9");
        expect_rd(A_BOTH, 8'h04, 1'b0, "R9");
        expect_rd(A_EN,   8'h07, 1'b0, "R9");
        expect_rd(A_CLR,  8'h00, 1'b0, "R9");
        // R3 rising edge on falling-sensed pin1 sets nothing
        pins(8'h02);
        expect_rd(A_RAW, 8'h00, 1'b0, "R3");
        // R2 rising edge on pin0, held after release
        pins(8'h03);
        expect_rd(A_RAW, 8'h01, 1'b1, "R2");
        pins(8'h02);
        expect_rd(A_RAW, 8'h01, 1'b1, "R2");
        // R3 falling edge on pin1
        pins(8'h00);
        expect_rd(A_RAW, 8'h03, 1'b1, "R3");
        expect_rd(A_MSK, 8'h03, 1'b1, "R6");
        // R7 clear with zero bits elsewhere
        wr(A_CLR, 8'h02);
        expect_rd(A_RAW, 8'h01, 1'b1, "R7");
        wr(A_CLR, 8'h01);
        expect_rd(A_RAW, 8'h00, 1'b0, "R7");
        // R10 steady pin gives no new event
        pins(8'h01);
        expect_rd(A_RAW, 8'h01, 1'b1, "R10");
        wr(A_CLR, 8'h01);
        expect_rd(A_RAW, 8'h00, 1'b0, "R10");
        // R8 edge coinciding with clear survives
        pins(8'h00);
        pins_and_clear(8'h01, 8'h01);
        expect_rd(A_RAW, 8'h01, 1'b1, "R8");
        wr(A_CLR, 8'h01);
        expect_rd(A_RAW, 8'h00, 1'b0, "R8");
        // R4 both edges on pin2, polarity 0 ignored
        pins(8'h05);
        expect_rd(A_RAW, 8'h04, 1'b1, "R4");
        wr(A_CLR, 8'h04);
        expect_rd(A_RAW, 8'h00, 1'b0, "R4");
        pins(8'h01);
        expect_rd(A_RAW, 8'h04, 1'b1, "R4");
        wr(A_CLR, 8'h04);
        // R6 masking
        wr(A_EN, 8'h00);
        pins(8'h05);
        expect_rd(A_RAW, 8'h04, 1'b0, "R6");
        expect_rd(A_MSK, 8'h00, 1'b0, "R6");
        wr(A_EN, 8'h04);
        expect_rd(A_MSK, 8'h04, 1'b1, "R6");
        wr(A_CLR, 8'h04);
        // R5 level high on pin3
        wr(A_SEN, 8'h08);
        wr(A_POL, 8'h09);
        wr(A_EN, 8'h08);
        pins(8'h0D);
        expect_rd(A_RAW, 8'h08, 1'b1, "R5");
        wr(A_CLR, 8'h08);
        expect_rd(A_RAW, 8'h08, 1'b1, "R7");
        pins(8'h05);
        expect_rd(A_RAW, 8'h00, 1'b0, "R5");
        // R5 level low on pin4
        wr(A_SEN, 8'h18);
        expect_rd(A_RAW, 8'h10, 1'b0, "R5");
        wr(A_EN, 8'h10);
        expect_rd(A_MSK, 8'h10, 1'b1, "R6");
        pins(8'h15);
        expect_rd(A_RAW, 8'h00, 1'b0, "R5");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule